// File: doc/BRIEF.md
# Variable-Length Bit Packer

The packer takes code words of 1 to 32 bits and joins them end to end, with no gaps, into one bit stream that leaves the block as 16-bit words. Each code arrives left-aligned in a 32-bit field, with a 5-bit length beside it. Only the top `length` bits of the field are used, and the first bit of the stream is the most significant bit of the first code.

A 64-bit accumulator holds the bits that have not yet been sent, and a 6-bit fill counter records how many there are. Once 16 or more bits are pending, the oldest 16 bits appear on the output. The block stops taking new codes whenever one more full-width code might not fit. At the end of a channel, a flush request sends out the remaining partial word with zeros in its low bits, then returns the block to empty.

On the input side, a code is taken in any cycle where `in_req` is high and `in_busy` is low. On the output side, a word is handed over in any cycle where `out_vd` and `out_ack` are both high.

Top module: `vlc_bit_packer`

## Requirements
- R1: After reset, `out_vd` and `in_busy` are low and no bits are pending.
- R2: `in_len` values 1 to 31 give the code length directly, and the value 0 means 32 bits. Field bits below the code length have no effect on the stream.
- R3: Codes are joined MSB-first with no gaps. Bit 15 of the first output word is the MSB of the first accepted code, and each later code begins right after the last bit of the code before it.
- R4: `out_vd` is high whenever 16 or more bits are pending. `out_word` is then the 16 oldest pending bits, with the oldest in bit 15.
- R5: While `out_vd` is high and `out_ack` is low, `out_word` holds its value and `out_vd` stays high.
- R6: `in_busy` is high whenever 32 or more bits are pending, so an accepted code of any length never overflows the 64-bit accumulator. A code presented while `in_busy` is high is not taken and leaves the stream unchanged.
- R7: A flush request taken while `in_busy` is low (a code in the same cycle is taken first) sends out every pending bit. The last partial word is padded with zeros in its low bits. `in_busy` stays high until the last word is acknowledged, after which the block is empty and `in_busy` is low.
- R8: A flush request with no bits pending produces no output word.
- R9: A word handed over and a code taken in the same cycle both take effect. A steady stream of 16-bit codes with `out_ack` held high never raises `in_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | A code is presented |
| in_code | input | 32 | Code, left-aligned |
| in_len | input | 5 | Code length in bits, 0 means 32 |
| in_flush | input | 1 | End-of-channel flush request |
| in_busy | output | 1 | High when the block cannot take a code or flush request |
| out_vd | output | 1 | `out_word` holds a word ready to send |
| out_word | output | 16 | Oldest 16 pending bits, oldest in bit 15 |
| out_ack | input | 1 | Consumer takes `out_word` this cycle |

## Verification
A misplaced shift amount or a wrong fill count shows up in the first output word after the faulty code. That word then carries bits that are shifted, duplicated or missing relative to the stream the bench rebuilds from the accepted codes. A fill counter that drifts low lets the accumulator overwrite pending bits, and one that drifts high leaves `in_busy` stuck or `out_vd` raised with no data behind it. Either fault becomes visible at the ports within a few cycles. Padding and flush-exit faults only appear at the end of a channel, in the last word and in whether the block returns to empty afterwards.

// File: rtl/vlc_bit_packer.sv
module vlc_bit_packer #(
  parameter int CODE_W = 32,
  parameter int LEN_W  = $clog2(CODE_W),
  parameter int ACC_W  = 64,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_flush,
  output logic              in_busy,
  output logic              out_vd,
  output logic [OUT_W-1:0]  out_word,
  input  logic              out_ack
);

  localparam int FILL_W     = $clog2(ACC_W);
  localparam int ACCEPT_MAX = ACC_W - CODE_W - 1;

  logic [ACC_W-1:0]  acc;
  logic [FILL_W-1:0] fill;
  logic              flushing;

  logic [LEN_W:0]     code_len;
  logic [CODE_W-1:0]  code_mask;
  logic [ACC_W-1:0]   code_full;
  logic               push, pop, flush_take;
  logic [ACC_W-1:0]   base_acc, next_acc;
  logic [FILL_W-1:0]  base_fill, next_fill;

  assign code_len  = (in_len == '0) ? (LEN_W+1)'(CODE_W) : {1'b0, in_len};
  assign code_mask = ~({CODE_W{1'b1}} >> code_len);
  assign code_full = {in_code & code_mask, {(ACC_W-CODE_W){1'b0}}};

  assign in_busy    = flushing || (fill > FILL_W'(ACCEPT_MAX));
  assign out_vd     = (fill >= FILL_W'(OUT_W)) || (flushing && fill != '0);
  assign out_word   = acc[ACC_W-1 -: OUT_W];
  assign push       = in_req && !in_busy;
  assign flush_take = in_flush && !in_busy;
  assign pop        = out_vd && out_ack;

  always_comb begin
    base_acc  = acc;
    base_fill = fill;
    if (pop) begin
      base_acc  = acc << OUT_W;
      base_fill = (fill >= FILL_W'(OUT_W)) ? fill - FILL_W'(OUT_W) : '0;
    end
    next_acc  = base_acc;
    next_fill = base_fill;
    if (push) begin
      next_acc  = base_acc | (code_full >> base_fill);
      next_fill = base_fill + FILL_W'(code_len);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      fill     <= '0;
      flushing <= 1'b0;
    end else begin
      acc  <= next_acc;
      fill <= next_fill;
      if (flushing || flush_take) flushing <= (next_fill != '0);
    end
  end

  p_vd_has_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_vd |-> (fill != '0));

  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vd && !out_ack) |=> (out_vd && $stable(out_word)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill <= FILL_W'(ACCEPT_MAX)));

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing && fill < FILL_W'(OUT_W) && fill != '0) |-> (OUT_W'(out_word << fill) == '0));

  p_flush_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing && pop && fill <= FILL_W'(OUT_W)) |=> (!flushing && fill == '0 && !out_vd && !in_busy));

  p_empty_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushing && fill == '0 && in_flush && !in_req) |=> !out_vd);

endmodule

// File: tb/vlc_bit_packer_tb_top.sv
module vlc_bit_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_req = 1'b0;
  logic [31:0] in_code = '0;
  logic [4:0]  in_len = '0;
  logic        in_flush = 1'b0;
  logic        in_busy, out_vd;
  logic [15:0] out_word;
  logic        out_ack = 1'b0;

  always #2 clk = ~clk;

  vlc_bit_packer dut_i (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_code(in_code), .in_len(in_len),
    .in_flush(in_flush), .in_busy(in_busy), .out_vd(out_vd), .out_word(out_word),
    .out_ack(out_ack)
  );

  localparam int NVEC = 16;
  localparam logic [36:0] VEC [0:NVEC-1] = '{
    {5'd3,  32'hA000_0000}, {5'd15, 32'hFFFE_0000}, {5'd1,  32'h8000_0000},
    {5'd0,  32'hDEAD_BEEF}, {5'd7,  32'h5B12_3456}, {5'd16, 32'h1234_FFFF},
    {5'd31, 32'h8765_4321}, {5'd2,  32'h4000_0000}, {5'd9,  32'hC480_0000},
    {5'd0,  32'h0F0F_0F0F}, {5'd5,  32'hFFFF_FFFF}, {5'd12, 32'hABC0_0001},
    {5'd1,  32'h7FFF_FFFF}, {5'd20, 32'h1357_9BDF}, {5'd4,  32'h9000_0000},
    {5'd11, 32'h3FF0_0000}
  };

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ack_mode = 0;
  bit ref_bits [0:8191];
  int wr = 0;
  int rd = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  always @(posedge clk) begin
    #1;
    case (ack_mode)
      0: out_ack = 1'b1;
      1: out_ack = (cyc % 3) != 2;
      default: out_ack = 1'b0;
    endcase
  end

  // Reference stream model, R2 R3 R4 R7
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_req && !in_busy) begin
        int n;
        n = (in_len == 0) ? 32 : int'(in_len);
        for (int i = 0; i < n; i++) ref_bits[wr + i] = in_code[31 - i];
        wr += n;
      end
      if (in_flush && !in_busy) wr = ((wr + 15) / 16) * 16;
      if (out_vd && out_ack) begin
        logic [15:0] e;
        for (int i = 0; i < 16; i++) e[15 - i] = ref_bits[rd + i];
        if (rd + 16 > wr) chk(1'b0, "R4 word without pending bits", {16'h0, out_word}, {16'h0, e});
        else chk(out_word == e, "R2 R3 R4 R7 stream word", {16'h0, out_word}, {16'h0, e});
        rd += 16;
      end
    end
  end

  task automatic push_code(input logic [4:0] len, input logic [31:0] code);
    @(posedge clk); #1;
    in_req = 1'b1; in_len = len; in_code = code;
    @(negedge clk);
    while (in_busy) @(negedge clk);
    @(posedge clk); #1;
    in_req = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1;
    in_flush = 1'b1;
    @(negedge clk);
    while (in_busy) @(negedge clk);
    @(posedge clk); #1;
    in_flush = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (in_busy || out_vd) @(negedge clk);
    chk(rd == wr, "R7 all bits emitted", rd, wr);
    chk(!in_busy && !out_vd, "R7 empty after flush", {in_busy, out_vd}, 0);
  endtask

  initial begin
    logic [15:0] w0;
    int busy_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_vd && !in_busy, "R1 outputs during reset", {out_vd, in_busy}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vd && !in_busy, "R1 outputs after reset", {out_vd, in_busy}, 0);

    for (int pass = 0; pass < 2; pass++) begin
      ack_mode = pass;
      for (int v = 0; v < NVEC; v++) push_code(VEC[v][36:32], VEC[v][31:0]);
      do_flush();
      drain();
    end

    // R5 hold and R6 busy/ignore
    ack_mode = 2;
    push_code(5'd0, 32'hCAFE_F00D);
    @(negedge clk);
    w0 = out_word;
    chk(w0 == 16'hCAFE, "R3 first word of 32-bit code", {16'h0, w0}, 32'hCAFE);
    chk(in_busy, "R6 busy at 32 pending bits", {31'h0, in_busy}, 1);
    @(posedge clk); #1;
    in_req = 1'b1; in_len = 5'd8; in_code = 32'hFF00_0000;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_vd && out_word == w0, "R5 word held without ack", {15'h0, out_vd, out_word}, {15'h0, 1'b1, w0});
      chk(in_busy, "R6 code not taken while busy", {31'h0, in_busy}, 1);
    end
    ack_mode = 0;
    @(negedge clk);
    while (in_busy) @(negedge clk);
    @(posedge clk); #1;
    in_req = 1'b0;
    do_flush();
    drain();

    // R8 flush with nothing pending
    do_flush();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!out_vd, "R8 no word from empty flush", {31'h0, out_vd}, 0);
    end
    chk(!in_busy, "R8 not busy after empty flush", {31'h0, in_busy}, 0);

    // R9 simultaneous take and hand-over
    busy_cnt = 0;
    @(posedge clk); #1;
    in_req = 1'b1; in_len = 5'd16;
    for (int i = 0; i < 20; i++) begin
      in_code = {16'(i * 16'h1111 + 1), 16'h0};
      @(negedge clk);
      if (in_busy) busy_cnt++;
      @(posedge clk); #1;
    end
    in_req = 1'b0;
    chk(busy_cnt == 0, "R9 no stall on steady 16-bit codes", busy_cnt, 0);
    do_flush();
    drain();

    report();
  end

endmodule